// File: doc/BRIEF.md
# Arithmetic Unit with Stored Condition Flags and Branch Test

This block is the execute-stage arithmetic unit of a small sequential processor. Each cycle it combines two 32-bit operands under a four-bit function code and drives the result on `valE`. The operand order is fixed: the result is always `valB OP valA`. Memory instructions compute their effective addresses with the same unit by selecting the add function.

Three condition flags are held in a register: zero, sign and signed overflow. They are loaded from the current result on a rising clock edge, but only when the `setCc` strobe is high and the function code is one of the four defined operations. Instructions that are not arithmetic or logical leave `setCc` low, so the flags keep their values.

A separate combinational path tests a four-bit condition code against the stored flags and drives `condTrue`. The surrounding control logic uses this output to decide conditional jumps and conditional moves.

Top module: `alu_cc`

## Requirements
- R1: Function code 0 gives `valE = valB + valA`, truncated to 32 bits.
- R2: Function code 1 gives `valE = valB - valA`, truncated to 32 bits.
- R3: Function code 2 gives the bitwise AND of `valB` and `valA`. Function code 3 gives their bitwise XOR.
- R4: Function codes 4 to 15 drive `valE` to 0, and `setCc` has no effect on the flags when one of these codes is present.
- R5: The flags change only on a rising clock edge while `setCc` is high and the function code is 0 to 3. On every other edge they keep their value.
- R6: When the flags load, the zero flag becomes 1 if the result is 0, and the sign flag becomes bit 31 of the result.
- R7: When the flags load, the overflow flag records signed two's-complement overflow for add and subtract, and is cleared for AND and XOR.
- R8: While `rstN` is low (asynchronous, active low), the zero flag is 1 and the sign and overflow flags are 0.
- R9: Condition codes map as follows. 0 is always true. 1 is (S^O)|Z. 2 is S^O. 3 is Z. 4 is !Z. 5 is !(S^O). 6 is !(S^O)&!Z. Codes 7 to 15 are always false.
- R10: `condTrue` depends only on the stored flags and `condFunc`, so it reflects newly loaded flags in the cycle right after the loading edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| valA | input | 32 | Right-hand operand |
| valB | input | 32 | Left-hand operand |
| aluFunc | input | 4 | Operation select |
| setCc | input | 1 | Strobe that loads the flags at the next edge |
| condFunc | input | 4 | Condition to test |
| valE | output | 32 | Operation result |
| zeroFlag | output | 1 | Stored zero flag |
| signFlag | output | 1 | Stored sign flag |
| ovfFlag | output | 1 | Stored overflow flag |
| condTrue | output | 1 | 1 when the selected condition holds |

## Verification
The bench goes after the overflow boundaries where a sum or difference crosses 0x7FFFFFFF or 0x80000000. A design with a reversed operand order or a wrong overflow rule would show a wrong sign on subtract, or a missing or spurious overflow flag. It also issues undefined function codes and cycles with the strobe low after the flags have loaded. A design that loads on any edge, or that decodes an undefined code as add, would corrupt the flags or produce a nonzero result there. Every condition code, including the unused ones, is compared against a reference model on each cycle. This catches a swapped less-than versus less-or-equal term, and a condition output driven from the unregistered result instead of the stored flags.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;
  localparam int FUNC_W = 4;

  typedef enum logic [2:0] {
    OP_ADD,
    OP_SUB,
    OP_AND,
    OP_XOR,
    OP_NONE
  } aluOp_e;

  typedef enum logic [FUNC_W-1:0] {
    C_ALWAYS = 4'd0,
    C_LE     = 4'd1,
    C_LT     = 4'd2,
    C_EQ     = 4'd3,
    C_NE     = 4'd4,
    C_GE     = 4'd5,
    C_GT     = 4'd6
  } cond_e;

  typedef struct packed {
    logic   loadFlags;
    aluOp_e op;
  } aluCtl_t;

  typedef struct packed {
    logic zero;
    logic sign;
    logic ovf;
  } flags_t;
endpackage

// File: rtl/alu_cc_ctrl.sv
module alu_cc_ctrl
  import alu_cc_pkg::*;
#(
  parameter int FW = FUNC_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [FW-1:0] aluFunc,
  input  logic          setCc,
  input  logic [FW-1:0] condFunc,
  input  flags_t        flags,
  output aluCtl_t       ctl,
  output logic          condTrue
);
  localparam int NUM_OPS = 4;

  aluOp_e opSel;
  logic   lessThan;

  always_comb begin
    if (aluFunc < FW'(NUM_OPS)) begin
      unique case (aluFunc[1:0])
        2'd0:    opSel = OP_ADD;
        2'd1:    opSel = OP_SUB;
        2'd2:    opSel = OP_AND;
        default: opSel = OP_XOR;
      endcase
    end else begin
      opSel = OP_NONE;
    end
  end

  assign ctl.op        = opSel;
  assign ctl.loadFlags = setCc && (opSel != OP_NONE);

  assign lessThan = flags.sign ^ flags.ovf;

  always_comb begin
    case (condFunc)
      C_ALWAYS: condTrue = 1'b1;
      C_LE:     condTrue = lessThan | flags.zero;
      C_LT:     condTrue = lessThan;
      C_EQ:     condTrue = flags.zero;
      C_NE:     condTrue = !flags.zero;
      C_GE:     condTrue = !lessThan;
      C_GT:     condTrue = !lessThan && !flags.zero;
      default:  condTrue = 1'b0;
    endcase
  end

  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (condFunc == FW'(0)) |-> condTrue); // R9
  AST_UNUSED_COND_FALSE: assert property (@(posedge clk) disable iff (!rstN)
    (condFunc > FW'(6)) |-> !condTrue); // R9
  AST_EQ_TRACKS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (condFunc == FW'(3)) |-> (condTrue == flags.zero)); // R10
  AST_GE_LT_SPLIT: assert property (@(posedge clk) disable iff (!rstN)
    (condFunc == FW'(5)) |-> (condTrue != (flags.sign ^ flags.ovf))); // R9
endmodule

// File: rtl/alu_cc_dp.sv
module alu_cc_dp
  import alu_cc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  aluCtl_t          ctl,
  input  logic [WIDTH-1:0] valA,
  input  logic [WIDTH-1:0] valB,
  output logic [WIDTH-1:0] valE,
  output flags_t           flags
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] sumRes;
  logic [WIDTH-1:0] diffRes;
  logic             addOvf;
  logic             subOvf;
  flags_t           nextFlags;
  flags_t           flagReg;

  assign sumRes  = valB + valA;
  assign diffRes = valB - valA;
  assign addOvf  = (valB[MSB] == valA[MSB]) && (sumRes[MSB] != valB[MSB]);
  assign subOvf  = (valB[MSB] != valA[MSB]) && (diffRes[MSB] != valB[MSB]);

  always_comb begin
    nextFlags.ovf = 1'b0;
    unique case (ctl.op)
      OP_ADD: begin
        valE          = sumRes;
        nextFlags.ovf = addOvf;
      end
      OP_SUB: begin
        valE          = diffRes;
        nextFlags.ovf = subOvf;
      end
      OP_AND:  valE = valB & valA;
      OP_XOR:  valE = valB ^ valA;
      default: valE = '0;
    endcase
    nextFlags.zero = (valE == '0);
    nextFlags.sign = valE[MSB];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagReg <= '{zero: 1'b1, sign: 1'b0, ovf: 1'b0};
    end else if (ctl.loadFlags) begin
      flagReg <= nextFlags;
    end
  end

  assign flags = flagReg;

  AST_HOLD_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadFlags |=> $stable(flags)); // R5
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadFlags |=> (flags.zero == ($past(valE) == '0))); // R6
  AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadFlags |=> (flags.sign == $past(valE[MSB]))); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadFlags && (ctl.op == OP_AND || ctl.op == OP_XOR)) |=> !flags.ovf); // R7
  AST_BAD_FUNC_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.op == OP_NONE) |-> (valE == '0)); // R4
endmodule

// File: rtl/alu_cc.sv
module alu_cc
  import alu_cc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WIDTH-1:0]  valA,
  input  logic [WIDTH-1:0]  valB,
  input  logic [FUNC_W-1:0] aluFunc,
  input  logic              setCc,
  input  logic [FUNC_W-1:0] condFunc,
  output logic [WIDTH-1:0]  valE,
  output logic              zeroFlag,
  output logic              signFlag,
  output logic              ovfFlag,
  output logic              condTrue
);
  aluCtl_t ctl;
  flags_t  flags;

  alu_cc_ctrl #(.FW(FUNC_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .aluFunc  (aluFunc),
    .setCc    (setCc),
    .condFunc (condFunc),
    .flags    (flags),
    .ctl      (ctl),
    .condTrue (condTrue)
  );

  alu_cc_dp #(.WIDTH(WIDTH)) uDp (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .valA  (valA),
    .valB  (valB),
    .valE  (valE),
    .flags (flags)
  );

  assign zeroFlag = flags.zero;
  assign signFlag = flags.sign;
  assign ovfFlag  = flags.ovf;
endmodule

// File: tb/alu_cc_test.sv
module alu_cc_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b1;
  logic [31:0] valA = '0;
  logic [31:0] valB = '0;
  logic [3:0]  aluFunc = '0;
  logic        setCc = 1'b0;
  logic [3:0]  condFunc = '0;
  logic [31:0] valE;
  logic        zeroFlag, signFlag, ovfFlag, condTrue;

  int checks = 0;
  int fails = 0;
  bit refZ = 1'b1, refS = 1'b0, refO = 1'b0;

  always #10 clk = ~clk;

  alu_cc uut (
    .clk(clk), .rstN(rstN), .valA(valA), .valB(valB), .aluFunc(aluFunc),
    .setCc(setCc), .condFunc(condFunc), .valE(valE), .zeroFlag(zeroFlag),
    .signFlag(signFlag), .ovfFlag(ovfFlag), .condTrue(condTrue)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] refResult(input logic [31:0] a, b, input int f);
    case (f)
      0: return b + a;
      1: return b - a;
      2: return b & a;
      3: return b ^ a;
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit refOvf(input logic [31:0] a, b, input int f);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint full;
    if (f == 0) full = sb + sa;
    else if (f == 1) full = sb - sa;
    else return 1'b0;
    return (full > 64'sd2147483647) || (full < -64'sd2147483648);
  endfunction

  function automatic bit refCond(input int c);
    bit lt = refS ^ refO;
    case (c)
      0: return 1'b1;
      1: return lt | refZ;
      2: return lt;
      3: return refZ;
      4: return !refZ;
      5: return !lt;
      6: return !lt && !refZ;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string resTag(input int f);
    case (f)
      0: return "R1";
      1: return "R2";
      2, 3: return "R3";
      default: return "R4";
    endcase
  endfunction

  // Drive after a falling edge, sample mid low phase, update model at the rising edge.
  task automatic step(input logic [31:0] a, b, input int f, input bit s, input int c,
                      input string flagTag);
    logic [31:0] r;
    @(negedge clk);
    valA = a; valB = b; aluFunc = 4'(f); setCc = s; condFunc = 4'(c);
    #5;
    r = refResult(a, b, f);
    chk(resTag(f), valE, r);
    chk({flagTag, " zero"}, 32'(zeroFlag), 32'(refZ));
    chk({flagTag, " sign"}, 32'(signFlag), 32'(refS));
    chk({flagTag, " ovf"}, 32'(ovfFlag), 32'(refO));
    chk("R9 cond", 32'(condTrue), 32'(refCond(c)));
    @(posedge clk);
    if (s && f < 4) begin
      refZ = (r == 32'd0);
      refS = r[31];
      refO = refOvf(a, b, f);
    end
  endtask

  task automatic sweepConds(input string tag);
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      setCc = 1'b0; condFunc = 4'(c);
      #5;
      chk(tag, 32'(condTrue), 32'(refCond(c)));
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1 rstN = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    chk("R8 zero", 32'(zeroFlag), 32'd1);
    chk("R8 sign", 32'(signFlag), 32'd0);
    chk("R8 ovf", 32'(ovfFlag), 32'd0);
    @(negedge clk) rstN = 1'b1;
    sweepConds("R9 reset flags");

    // add overflow boundaries
    step(32'h0000_0001, 32'h7FFF_FFFF, 0, 1, 3, "R7");
    step(32'h8000_0000, 32'h8000_0000, 0, 1, 1, "R7");
    step(32'h0000_0005, 32'h0000_0003, 0, 1, 2, "R6");
    // subtract ordering and overflow
    step(32'h0000_0001, 32'h8000_0000, 1, 1, 6, "R7");
    step(32'h0000_0003, 32'h0000_0003, 1, 1, 4, "R6");
    step(32'h0000_0007, 32'h0000_0002, 1, 1, 5, "R2");
    step(32'hFFFF_FFFF, 32'h7FFF_FFFF, 1, 1, 2, "R7");
    // logical ops clear overflow
    step(32'hF0F0_F0F0, 32'hFF00_FF00, 2, 1, 0, "R7");
    step(32'h1234_5678, 32'h1234_5678, 3, 1, 3, "R6");
    step(32'h0F0F_0F0F, 32'hF0F0_F0F0, 2, 1, 3, "R3");
    step(32'h0000_0001, 32'h7FFF_FFFF, 0, 1, 0, "R7");
    // load then read new flags on every condition the next cycle
    sweepConds("R10 new flags");
    // strobe low: flags hold
    step(32'h0, 32'h0, 0, 0, 3, "R5");
    step(32'h1, 32'h8000_0000, 1, 0, 4, "R5");
    step(32'h5, 32'h9, 3, 0, 1, "R5");
    // undefined function codes with strobe high
    step(32'hAAAA_AAAA, 32'h5555_5555, 4, 1, 0, "R4");
    step(32'h1, 32'h1, 15, 1, 3, "R4");
    step(32'h0, 32'h0, 9, 1, 4, "R4");
    sweepConds("R4 flags kept");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      int f;
      a = $urandom;
      b = $urandom;
      if (i % 7 == 0) b = a;
      if (i % 11 == 0) a = 32'h8000_0000;
      f = (i % 9 == 0) ? int'($urandom_range(15, 4)) : int'($urandom_range(3, 0));
      step(a, b, f, 1'($urandom), int'($urandom_range(15, 0)), "R6");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule